// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the fetch stage of a processor and runs counted loops without branch instructions. It holds two loop register sets. Each set has a start address, an end address and a remaining iteration count. When the address being fetched equals the end address of a set whose count is not zero, the controller either sends fetch back to that set's start address or lets it fall through on the last pass. It updates the count in both cases. With two sets, two loops can be nested, and set 0 is the inner one.

The decoder programs the sets through a small configuration port. One operation, one cycle: it writes one field of one set, or all three fields of one set at once. Addresses are formed relative to the program counter of the setup operation. The count comes either from a register operand or from an immediate. The redirect decision is combinational from the stored state and the fetch address, so a taken loop-back costs no fetch cycle. All state updates take effect at the next rising clock edge.

Top module: `hwloop_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every start address, end address and count to zero. No redirect is produced until a set is programmed.
- R2: A set whose count is 0 never produces a redirect, even when its end address equals the fetch address.
- R3: When fetch_valid is high, fetch_pc equals the end address of the acting set, and that set's count is greater than 1, redirect_o is high in the same cycle and redirect_pc_o equals that set's start address. The count drops by exactly 1 at the next edge.
- R4: When the acting set's count is exactly 1 at its end address, redirect_o stays low and the count becomes 0 at the next edge.
- R5: While fetch_valid is low, no redirect is produced and no count changes.
- R6: Field-wise operations take effect on the set selected by cfg_set. The cfg_op encodings are:
  - 1: start address becomes cfg_pc + cfg_imm_a.
  - 2: end address becomes cfg_pc + cfg_imm_a.
  - 3: count becomes cfg_rs, the register operand.
  - 4: count becomes cfg_imm_c.
  - 0: no operation.
- R7: The combined operations write all three fields of the selected set. In both, start becomes cfg_pc + 4 (the next instruction) and end becomes cfg_pc + cfg_imm_a. Encoding 5 loads the count from cfg_rs; encoding 6 loads it from cfg_imm_c.
- R8: The two sets are independent. A write to one set changes nothing in the other.
- R9: The acting set is the lowest-numbered set that has a non-zero count and whose end address equals fetch_pc. When set 0 acts, set 1 keeps its count in that cycle, even if its own end address also matches.
- R10: A configuration write and an end-address match on the same set can fall in the same cycle. The redirect decision then uses the values stored before the write. A count written in that cycle replaces the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_op | input | 3 | Configuration operation code (R6, R7) |
| cfg_set | input | 1 | Loop set selected by the operation |
| cfg_pc | input | ADDR_W | Program counter of the setup operation |
| cfg_imm_a | input | ADDR_W | Address offset immediate |
| cfg_imm_c | input | CNT_W | Count immediate |
| cfg_rs | input | CNT_W | Count from register operand |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | ADDR_W | Address being fetched |
| redirect_o | output | 1 | Send fetch to redirect_pc_o |
| redirect_pc_o | output | ADDR_W | Loop start address to fetch next |

## Verification
Two kinds of event can coincide. In the first, a configuration write lands on a set in the same cycle that the fetch address hits that set's end. The bench provokes this by issuing a count write while fetching the end address of a running loop. It judges the result in two places: the redirect seen in that cycle must follow the old state, and the number of further loop-backs must follow the newly written count rather than a decremented one. In the second, both sets share one end address, as in tightly nested loops. There the sequence of redirect targets, first the inner start and then the outer start, shows that set 0 takes precedence and that set 1's count is untouched until set 0 is exhausted.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_START     = 3'd1,
    OP_END       = 3'd2,
    OP_CNT_REG   = 3'd3,
    OP_CNT_IMM   = 3'd4,
    OP_SETUP_REG = 3'd5,
    OP_SETUP_IMM = 3'd6
  } hwl_op_e;

endpackage

// File: rtl/hwloop_cfg_decode.sv
module hwloop_cfg_decode
  import hwloop_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int NUM_SETS    = 2,
  parameter int INSTR_BYTES = 4,
  localparam int SET_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic [2:0]          op_i,
  input  logic [SET_W-1:0]    set_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [ADDR_W-1:0]   imm_a_i,
  input  logic [CNT_W-1:0]    imm_c_i,
  input  logic [CNT_W-1:0]    rs_i,
  output logic [NUM_SETS-1:0] we_start_o,
  output logic [NUM_SETS-1:0] we_end_o,
  output logic [NUM_SETS-1:0] we_cnt_o,
  output logic [ADDR_W-1:0]   start_val_o,
  output logic [ADDR_W-1:0]   end_val_o,
  output logic [CNT_W-1:0]    cnt_val_o
);

  hwl_op_e op;
  logic    is_setup;
  logic    hit_start;
  logic    hit_end;
  logic    hit_cnt;
  logic    cnt_from_reg;

  always_comb begin
    op           = hwl_op_e'(op_i);
    is_setup     = (op == OP_SETUP_REG) || (op == OP_SETUP_IMM);
    hit_start    = (op == OP_START) || is_setup;
    hit_end      = (op == OP_END) || is_setup;
    hit_cnt      = (op == OP_CNT_REG) || (op == OP_CNT_IMM) || is_setup;
    cnt_from_reg = (op == OP_CNT_REG) || (op == OP_SETUP_REG);
    start_val_o  = is_setup ? (pc_i + ADDR_W'(INSTR_BYTES)) : (pc_i + imm_a_i);
    end_val_o    = pc_i + imm_a_i;
    cnt_val_o    = cnt_from_reg ? rs_i : imm_c_i;
  end

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_sel
    logic picked;
    assign picked        = (set_i == SET_W'(g));
    assign we_start_o[g] = picked && hit_start;
    assign we_end_o[g]   = picked && hit_end;
    assign we_cnt_o[g]   = picked && hit_cnt;
  end

endmodule

// File: rtl/hwloop_regset.sv
module hwloop_regset #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_start_i,
  input  logic              we_end_i,
  input  logic              we_cnt_i,
  input  logic [ADDR_W-1:0] start_val_i,
  input  logic [ADDR_W-1:0] end_val_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] end_q,
  output logic [CNT_W-1:0]  cnt_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (we_start_i) start_q <= start_val_i;
      if (we_end_i)   end_q   <= end_val_i;
      // a fresh count written by the decoder outranks the loop decrement
      if (we_cnt_i)   cnt_q   <= cnt_val_i;
      else if (dec_i) cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/hwloop_arbiter.sv
module hwloop_arbiter #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int NUM_SETS = 2
) (
  input  logic                             fetch_valid_i,
  input  logic [ADDR_W-1:0]                fetch_pc_i,
  input  logic [NUM_SETS-1:0][ADDR_W-1:0]  start_i,
  input  logic [NUM_SETS-1:0][ADDR_W-1:0]  end_i,
  input  logic [NUM_SETS-1:0][CNT_W-1:0]   cnt_i,
  output logic [NUM_SETS-1:0]              act_o,
  output logic                             redirect_o,
  output logic [ADDR_W-1:0]                redirect_pc_o
);

  logic [NUM_SETS-1:0] hit;
  logic [NUM_SETS-1:0] last;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_cmp
    assign hit[g]  = fetch_valid_i && (fetch_pc_i == end_i[g]) && (cnt_i[g] != '0);
    assign last[g] = (cnt_i[g] == CNT_W'(1));
  end

  always_comb begin
    logic taken;
    taken         = 1'b0;
    act_o         = '0;
    redirect_pc_o = '0;
    for (int i = 0; i < NUM_SETS; i++) begin
      if (hit[i] && !taken) begin
        act_o[i] = 1'b1;
        taken    = 1'b1;
        if (!last[i]) redirect_pc_o = start_i[i];
      end
    end
    redirect_o = |(act_o & ~last);
  end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int NUM_SETS    = 2,
  parameter int INSTR_BYTES = 4,
  localparam int SET_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_op,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic [ADDR_W-1:0] cfg_pc,
  input  logic [ADDR_W-1:0] cfg_imm_a,
  input  logic [CNT_W-1:0]  cfg_imm_c,
  input  logic [CNT_W-1:0]  cfg_rs,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);

  logic [NUM_SETS-1:0]             we_start;
  logic [NUM_SETS-1:0]             we_end;
  logic [NUM_SETS-1:0]             we_cnt;
  logic [ADDR_W-1:0]               start_val;
  logic [ADDR_W-1:0]               end_val;
  logic [CNT_W-1:0]                cnt_val;
  logic [NUM_SETS-1:0]             act;
  logic [NUM_SETS-1:0][ADDR_W-1:0] start_q;
  logic [NUM_SETS-1:0][ADDR_W-1:0] end_q;
  logic [NUM_SETS-1:0][CNT_W-1:0]  cnt_q;

  hwloop_cfg_decode #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_SETS(NUM_SETS), .INSTR_BYTES(INSTR_BYTES)
  ) u_dec (
    .op_i(cfg_op), .set_i(cfg_set), .pc_i(cfg_pc), .imm_a_i(cfg_imm_a),
    .imm_c_i(cfg_imm_c), .rs_i(cfg_rs),
    .we_start_o(we_start), .we_end_o(we_end), .we_cnt_o(we_cnt),
    .start_val_o(start_val), .end_val_o(end_val), .cnt_val_o(cnt_val)
  );

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    hwloop_regset #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_set (
      .clk(clk), .rst(rst),
      .we_start_i(we_start[g]), .we_end_i(we_end[g]), .we_cnt_i(we_cnt[g]),
      .start_val_i(start_val), .end_val_i(end_val), .cnt_val_i(cnt_val),
      .dec_i(act[g]),
      .start_q(start_q[g]), .end_q(end_q[g]), .cnt_q(cnt_q[g])
    );
  end

  hwloop_arbiter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_SETS(NUM_SETS)) u_arb (
    .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc),
    .start_i(start_q), .end_i(end_q), .cnt_i(cnt_q),
    .act_o(act), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int SET_W  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cfg_op,
  input logic [SET_W-1:0]  cfg_set,
  input logic [CNT_W-1:0]  cfg_imm_c,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] end0,
  input logic [ADDR_W-1:0] end1,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1
);

  logic cnt_wr;
  logic any_wr1;
  assign cnt_wr  = (cfg_op == OP_CNT_REG) || (cfg_op == OP_CNT_IMM) ||
                   (cfg_op == OP_SETUP_REG) || (cfg_op == OP_SETUP_IMM);
  assign any_wr1 = (cfg_op != OP_NONE) && (cfg_set == SET_W'(1));

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt0 == '0 && cnt1 == '0));

  // R2
  idle_no_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt0 == '0 && cnt1 == '0) |-> !redirect_o);

  // R3
  loop_back_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_pc == end0 && cnt0 > CNT_W'(1)) |-> redirect_o);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_pc == end0 && cnt0 > CNT_W'(1) &&
     !(cnt_wr && cfg_set == SET_W'(0))) |=> (cnt0 == $past(cnt0) - CNT_W'(1)));

  // R4
  last_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_pc == end0 && cnt0 == CNT_W'(1)) |-> !redirect_o);

  // R5
  no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> !redirect_o);

  // R9
  inner_first_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_pc == end0 && cnt0 != '0 && fetch_pc == end1 && !any_wr1)
    |=> $stable(cnt1));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_op == OP_CNT_IMM && cfg_set == SET_W'(0)) |=> (cnt0 == $past(cfg_imm_c)));

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SET_W(SET_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_op(cfg_op), .cfg_set(cfg_set), .cfg_imm_c(cfg_imm_c),
  .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .redirect_o(redirect_o),
  .end0(end_q[0]), .end1(end_q[1]), .cnt0(cnt_q[0]), .cnt1(cnt_q[1])
);

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb;

  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cfg_op = '0;
  logic [0:0]    cfg_set = '0;
  logic [AW-1:0] cfg_pc = '0;
  logic [AW-1:0] cfg_imm_a = '0;
  logic [CW-1:0] cfg_imm_c = '0;
  logic [CW-1:0] cfg_rs = '0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          redirect_o;
  logic [AW-1:0] redirect_pc_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  hwloop_ctrl #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .cfg_op(cfg_op), .cfg_set(cfg_set), .cfg_pc(cfg_pc),
    .cfg_imm_a(cfg_imm_a), .cfg_imm_c(cfg_imm_c), .cfg_rs(cfg_rs),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  typedef struct packed {
    logic [2:0]    op;
    logic          set;
    logic [AW-1:0] pc;
    logic [AW-1:0] imm_a;
    logic [CW-1:0] imm_c;
    logic [CW-1:0] rs;
    logic          fv;
    logic [AW-1:0] fpc;
    logic          exp_r;
    logic [AW-1:0] exp_pc;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 24;
  // op codes: 0 none, 1 start, 2 end, 3 count reg, 4 count imm, 5 setup reg, 6 setup imm
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h0,   1'b0, 32'h0,   8'd1},  // R1 end 0, count 0
    '{3'd6, 1'b0, 32'h100, 32'h10, 16'd3, 16'd0, 1'b1, 32'h110, 1'b0, 32'h0,   8'd10}, // R10 old state used
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h110, 1'b1, 32'h104, 8'd7},  // R7 start = pc+4
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h108, 1'b0, 32'h0,   8'd3},  // R3 no match
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h110, 1'b1, 32'h104, 8'd3},  // R3 second pass
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h110, 1'b0, 32'h0,   8'd4},  // R4 last pass
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h110, 1'b0, 32'h0,   8'd2},  // R2 exhausted
    '{3'd1, 1'b1, 32'h200, 32'h20, 16'd0, 16'd0, 1'b0, 32'h0,   1'b0, 32'h0,   8'd6},  // R6 start field
    '{3'd2, 1'b1, 32'h200, 32'h40, 16'd0, 16'd0, 1'b0, 32'h0,   1'b0, 32'h0,   8'd6},  // R6 end field
    '{3'd3, 1'b1, 32'h0,   32'h0,  16'd9, 16'd2, 1'b0, 32'h0,   1'b0, 32'h0,   8'd6},  // R6 count from reg
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h240, 1'b1, 32'h220, 8'd8},  // R8 set 1 alone
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b0, 32'h240, 1'b0, 32'h0,   8'd5},  // R5 invalid fetch
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h240, 1'b0, 32'h0,   8'd5},  // R5 count kept at 1
    '{3'd5, 1'b0, 32'h300, 32'h20, 16'd7, 16'd2, 1'b0, 32'h0,   1'b0, 32'h0,   8'd7},  // R7 setup reg form
    '{3'd6, 1'b1, 32'h2FC, 32'h24, 16'd2, 16'd0, 1'b0, 32'h0,   1'b0, 32'h0,   8'd7},  // R7 setup imm form
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h320, 1'b1, 32'h304, 8'd9},  // R9 inner first
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h320, 1'b0, 32'h0,   8'd9},  // R9 inner falls out
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h320, 1'b1, 32'h300, 8'd9},  // R9 outer count intact
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h320, 1'b0, 32'h0,   8'd4},  // R4 outer last
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h320, 1'b0, 32'h0,   8'd2},  // R2 both zero
    '{3'd4, 1'b0, 32'h0,   32'h0,  16'd5, 16'd0, 1'b1, 32'h320, 1'b0, 32'h0,   8'd10}, // R10 old count 0
    '{3'd4, 1'b0, 32'h0,   32'h0,  16'd2, 16'd0, 1'b1, 32'h320, 1'b1, 32'h304, 8'd10}, // R10 redirect on old 5
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h320, 1'b1, 32'h304, 8'd10}, // R10 written 2 kept
    '{3'd0, 1'b0, 32'h0,   32'h0,  16'd0, 16'd0, 1'b1, 32'h320, 1'b0, 32'h0,   8'd10}  // R10 not 4
  };

  task automatic drive(input logic [2:0] op, input logic st, input logic [AW-1:0] pc,
                       input logic [AW-1:0] ia, input logic [CW-1:0] ic,
                       input logic [CW-1:0] rs, input logic fv, input logic [AW-1:0] fpc);
    cfg_op = op; cfg_set = st; cfg_pc = pc; cfg_imm_a = ia; cfg_imm_c = ic;
    cfg_rs = rs; fetch_valid = fv; fetch_pc = fpc;
  endtask

  task automatic check(input int req, input logic er, input logic [AW-1:0] epc);
    total++;
    if (redirect_o !== er || (er && redirect_pc_o !== epc)) begin
      bad++;
      $display("FAIL R%0d: redirect=%0b pc=%h expected redirect=%0b pc=%h",
               req, redirect_o, redirect_pc_o, er, epc);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic st, input logic [AW-1:0] pc,
                      input logic [AW-1:0] ia, input logic [CW-1:0] ic,
                      input logic [CW-1:0] rs, input logic fv, input logic [AW-1:0] fpc,
                      input int req, input logic er, input logic [AW-1:0] epc);
    @(negedge clk);
    drive(op, st, pc, ia, ic, rs, fv, fpc);
    #2;
    check(req, er, epc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].op, TBL[i].set, TBL[i].pc, TBL[i].imm_a, TBL[i].imm_c, TBL[i].rs,
           TBL[i].fv, TBL[i].fpc, int'(TBL[i].req), TBL[i].exp_r, TBL[i].exp_pc);
    end

    // R3: wide count, set 0 at 0x404..0x408, count 0xFFFF loops twice in a row
    step(3'd6, 1'b0, 32'h400, 32'h8, 16'hFFFF, 16'd0, 1'b0, 32'h0, 3, 1'b0, 32'h0);
    step(3'd0, 1'b0, 32'h0, 32'h0, 16'd0, 16'd0, 1'b1, 32'h408, 3, 1'b1, 32'h404);
    step(3'd0, 1'b0, 32'h0, 32'h0, 16'd0, 16'd0, 1'b1, 32'h408, 3, 1'b1, 32'h404);

    // R1: reset in the middle of a loop clears the running set
    @(negedge clk);
    drive(3'd0, 1'b0, '0, '0, '0, '0, 1'b0, '0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #2;
    drive(3'd0, 1'b0, '0, '0, '0, '0, 1'b1, 32'h408);
    #1;
    check(1, 1'b0, 32'h0);
    step(3'd0, 1'b0, 32'h0, 32'h0, 16'd0, 16'd0, 1'b1, 32'h0, 1, 1'b0, 32'h0);

    // R8: programming set 1 leaves set 0 empty
    step(3'd6, 1'b1, 32'h500, 32'h10, 16'd3, 16'd0, 1'b0, 32'h0, 8, 1'b0, 32'h0);
    step(3'd0, 1'b0, 32'h0, 32'h0, 16'd0, 16'd0, 1'b1, 32'h510, 8, 1'b1, 32'h504);
    step(3'd0, 1'b0, 32'h0, 32'h0, 16'd0, 16'd0, 1'b1, 32'h0, 8, 1'b0, 32'h0);

    @(negedge clk);
    drive(3'd0, 1'b0, '0, '0, '0, '0, 1'b0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule